// File: doc/BRIEF.md
# PC Card Function Configuration Registers

This block holds the two attribute-space configuration registers of a PC card function: an option register that sets the operating mode, and a status register that reports interrupt state and controls power-down. The host reaches them through a small register port with an address, byte-wide write and read data, and write and read strobes. The card's internal logic takes four signals from the block. The first is a held soft reset. The second selects whether the card decodes only memory cycles or also decodes I/O cycles. The third is a power-down request. The fourth is the active-low interrupt line to the host, which runs either as a level or as a fixed-length pulse.

The block takes one input from the card function, the interrupt source. The pending bit in the status register follows this source and cannot be cleared by the host. A hardware reset enters asynchronously and is released through a two-flop synchronizer.

Top module: `card_cfg_regs`

## Requirements
- R1: After hardware reset, both registers read 0x00, `soft_rst` is 0, `io_mode` is 0, `pwr_down_req` is 0 and `host_irq_n` is 1.
- R2: A write to offset 0 stores the option register: bit 7 is soft reset, bit 6 is level-interrupt enable (0 = pulse), and bits 5:0 are the configuration index. Bit 7 drives `soft_rst`, and writing 0 to bit 7 releases it.
- R3: While option bit 7 is 1, the configuration index reads 000000 and `pwr_down_req` is held at 0. Bit 6 and bit 7 stay writable during this time.
- R4: `io_mode` is 1 only when the index is 000001 and soft reset is off. Any other index value reads back exactly as written and selects memory mode.
- R5: A write to offset 2 sets bit 2, which drives `pwr_down_req` and reads back at bit 2.
- R6: Status bit 1 reads the interrupt source as sampled one clock earlier, and host writes do not change it. Status bits 7:3 and bit 0 always read 0.
- R7: Reads of any offset other than 0 or 2 return 0x00. Writes to those offsets change neither register.
- R8: In level mode with I/O mode on, `host_irq_n` is low exactly while status bit 1 is 1.
- R9: In pulse mode with I/O mode on, each rising edge of the interrupt source gives a low pulse on `host_irq_n` that lasts exactly PULSE_LEN (8) clock cycles.
- R10: A new source edge that arrives during a pulse restarts the pulse count.
- R11: `host_irq_n` stays high while in memory mode or under soft reset. A pulse that was started or pending when the mask applied is discarded, not delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_addr | input | ADDR_W (4) | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; read data is valid while it is high |
| reg_rdata | output | 8 | Read data, 0x00 when no read is in progress |
| irq_src | input | 1 | Interrupt source from the card function |
| soft_rst | output | 1 | Held soft reset to the card logic |
| io_mode | output | 1 | 1 = I/O cycles decoded, 0 = memory only |
| pwr_down_req | output | 1 | Power-down request |
| host_irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The clash that needs the most care is a host write that sets soft reset landing on the same clock edge as a rising edge of the interrupt source while the card is in pulse mode. The bench drives the write strobe and the source edge from the same falling edge, so both are captured by the next rising edge. It then checks that `host_irq_n` never goes low, neither during the reset nor after the host releases it and restores I/O mode, because the captured edge must be discarded and not replayed. A second overlap, a host write to the status register while the source is pending, is judged by reading bit 1 back as still set.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 6;

  localparam logic [IDX_W-1:0] IDX_MEM = 6'd0;
  localparam logic [IDX_W-1:0] IDX_IO  = 6'd1;

  typedef struct packed {
    logic             srst;
    logic             lvl;
    logic [IDX_W-1:0] idx;
  } opt_reg_t;
endpackage

// File: rtl/cfg_opt_reg.sv
module cfg_opt_reg
  import card_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output opt_reg_t          opt_q
);
  opt_reg_t opt_d;

  always_comb begin
    opt_d = opt_q;
    if (wr_en) opt_d = opt_reg_t'(wdata);
    if (opt_d.srst) opt_d.idx = IDX_MEM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_q <= '0;
    else        opt_q <= opt_d;
  end

  // R3: index held at zero throughout soft reset
  assert_idx_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    opt_q.srst |-> (opt_q.idx == IDX_MEM));
endmodule

// File: rtl/cfg_stat_reg.sv
module cfg_stat_reg
  import card_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              soft_rst,
  input  logic              irq_src,
  output logic              pwr_q,
  output logic              pend_q
);
  logic pwr_d;

  always_comb begin
    pwr_d = pwr_q;
    if (soft_rst)   pwr_d = 1'b0;
    else if (wr_en) pwr_d = wdata[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pwr_q  <= pwr_d;
      pend_q <= irq_src;
    end
  end

  assert_pwr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !pwr_q);

  assert_pend_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pend_q == $past(irq_src)));
endmodule

// File: rtl/irq_shaper.sv
module irq_shaper #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic lvl_mode,
  input  logic mask,
  output logic irq_n
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic             pend_d;
  logic             rise;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active;

  assign rise = pend & ~pend_d;

  always_comb begin
    cnt_d = cnt_q;
    if (mask)              cnt_d = '0;
    else if (rise)         cnt_d = CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_d <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_d <= pend;
      cnt_q  <= cnt_d;
    end
  end

  assign active = lvl_mode ? pend : (cnt_q != '0);
  assign irq_n  = ~(active & ~mask);

  // R9 / R10: every unmasked edge (re)loads a full pulse
  assert_pulse_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !mask) |=> (cnt_q == CNT_W'(PULSE_LEN)));

  assert_pulse_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PULSE_LEN));
endmodule

// File: rtl/card_cfg_regs.sv
module card_cfg_regs
  import card_cfg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  input  logic              irq_src,
  output logic              soft_rst,
  output logic              io_mode,
  output logic              pwr_down_req,
  output logic              host_irq_n
);
  localparam logic [ADDR_W-1:0] OFF_OPT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(2);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic     sel_opt, sel_stat;
  opt_reg_t opt_q;
  logic     pwr_q, pend_q;

  assign sel_opt  = (reg_addr == OFF_OPT);
  assign sel_stat = (reg_addr == OFF_STAT);

  cfg_opt_reg u_opt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr_en (reg_wr & sel_opt),
    .wdata (reg_wdata),
    .opt_q (opt_q)
  );

  cfg_stat_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (reg_wr & sel_stat),
    .wdata    (reg_wdata),
    .soft_rst (opt_q.srst),
    .irq_src  (irq_src),
    .pwr_q    (pwr_q),
    .pend_q   (pend_q)
  );

  assign soft_rst     = opt_q.srst;
  assign io_mode      = (opt_q.idx == IDX_IO) & ~opt_q.srst;
  assign pwr_down_req = pwr_q;

  irq_shaper #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .pend     (pend_q),
    .lvl_mode (opt_q.lvl),
    .mask     (~io_mode),
    .irq_n    (host_irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_opt)       reg_rdata = opt_q;
      else if (sel_stat) reg_rdata = {5'b0, pwr_q, pend_q, 1'b0};
    end
  end

  assert_mask_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !io_mode |-> host_irq_n);

  assert_other_off_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_wr && !sel_opt && !sel_stat && !opt_q.srst) |=> ($stable(opt_q) && $stable(pwr_q)));

  assert_level_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (io_mode && opt_q.lvl && $stable(opt_q)) |-> (host_irq_n == !pend_q));
endmodule

// File: tb/card_cfg_regs_bench.sv
module card_cfg_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_rdata;
  logic       irq_src;
  logic       soft_rst, io_mode, pwr_down_req, host_irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  card_cfg_regs u_card_cfg_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_src(irq_src),
    .soft_rst(soft_rst), .io_mode(io_mode), .pwr_down_req(pwr_down_req),
    .host_irq_n(host_irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!host_irq_n) lows++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); check("R1 opt", d, 8'h00);
    rd(2, d); check("R1 stat", d, 8'h00);
    check("R1 outs", {soft_rst, io_mode, pwr_down_req, host_irq_n}, 4'b0001);
  endtask

  task automatic t_opt_modes();
    logic [7:0] d;
    wr(0, 8'h01); rd(0, d);
    check("R2 readback", d, 8'h01);
    check("R4 io on", io_mode, 1);
    wr(0, 8'h42); rd(0, d);
    check("R4 index kept", d, 8'h42);
    check("R4 odd index is memory", io_mode, 0);
    wr(0, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    wr(2, 8'hFF); rd(2, d);
    check("R5/R6 pwr set, reserved zero", d, 8'h04);
    check("R5 pwr out", pwr_down_req, 1);
    irq_src = 1'b1;
    wr(2, 8'h00); rd(2, d);
    check("R6 pending not cleared by write", d, 8'h02);
    irq_src = 1'b0;
    @(negedge clk); rd(2, d);
    check("R6 pending follows source", d, 8'h00);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    wr(0, 8'h01); wr(2, 8'h04);
    wr(0, 8'h81); rd(0, d);
    check("R3 index cleared", d, 8'h80);
    check("R2 soft_rst out", soft_rst, 1);
    check("R3 pwr cleared", pwr_down_req, 0);
    wr(2, 8'h04); rd(2, d);
    check("R3 pwr held off", d, 8'h00);
    wr(0, 8'hC1); rd(0, d);
    check("R3 bit6 writable, index held", d, 8'hC0);
    check("R11 masked in soft reset", io_mode, 0);
    wr(0, 8'h00); rd(0, d);
    check("R2 release", {soft_rst, d}, 9'h000);
  endtask

  task automatic t_other_offsets();
    logic [7:0] d;
    wr(0, 8'h01); wr(2, 8'h04);
    for (int a = 1; a < 16; a++) if (a != 2) wr(a[3:0], 8'hFF);
    rd(5, d); check("R7 read other", d, 8'h00);
    rd(1, d); check("R7 read odd", d, 8'h00);
    rd(0, d); check("R7 opt untouched", d, 8'h01);
    rd(2, d); check("R7 stat untouched", d, 8'h04);
    wr(2, 8'h00); wr(0, 8'h00);
  endtask

  task automatic t_level();
    int lows;
    wr(0, 8'h41);
    irq_src = 1'b1;
    count_low(6, lows); check("R8 level low while pending", lows, 6);
    irq_src = 1'b0;
    @(negedge clk); count_low(5, lows); check("R8 level released", lows, 0);
    wr(0, 8'h40);
    irq_src = 1'b1;
    count_low(6, lows); check("R11 memory mode masks", lows, 0);
    irq_src = 1'b0; wr(0, 8'h00); @(negedge clk);
  endtask

  task automatic t_pulse();
    int lows;
    wr(0, 8'h01);
    irq_src = 1'b1;
    count_low(14, lows); check("R9 pulse length", lows, 8);
    irq_src = 1'b0; @(negedge clk); @(negedge clk);
    irq_src = 1'b1;
    lows = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (!host_irq_n) lows++;
      if (i == 0) irq_src = 1'b0;
      if (i == 1) irq_src = 1'b1;
    end
    check("R10 retrigger restarts", lows, 10);
    irq_src = 1'b0; @(negedge clk);
  endtask

  task automatic t_clash();
    int lows;
    wr(0, 8'h01); @(negedge clk);
    reg_addr = 4'd0; reg_wdata = 8'h81; reg_wr = 1'b1; irq_src = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    count_low(10, lows); check("R11 edge during soft reset dropped", lows, 0);
    wr(0, 8'h01);
    count_low(12, lows); check("R11 no replay after release", lows, 0);
    irq_src = 1'b0; wr(0, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0;
    reg_rd = 1'b0; irq_src = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_opt_modes();
    t_status();
    t_soft_reset();
    t_other_offsets();
    t_level();
    t_pulse();
    t_clash();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule